// File: doc/BRIEF.md
# Elastic Predicated Two-Way Select

This block is a latency-insensitive select that performs partial predication inside a dataflow fabric. Two candidate data operands are computed speculatively upstream and arrive as separate tokens. A third token carries a condition word. The unit reduces the condition word to a single-bit predicate. It then emits exactly one of the two operands on its output channel. The other operand is consumed and discarded.

Each of the three inputs and the output uses a valid/stop handshake. Valid flows downstream and stop flows upstream as back-pressure. The predicate is not a static mux select line. It is a token in its own right, and it is joined with both data tokens. A condition is therefore only ever consumed together with the operand pair it belongs to. The result is held in a single-entry output register, so the output is registered. That register can take a new result in the same cycle that its current result drains.

Top module: `elastic_pred_select`

## Requirements
- R1: When the condition word is nonzero, the emitted result equals operand A. Any single set bit counts, including only bit 0 or only the top bit.
- R2: When the condition word is all zeros, the emitted result equals operand B.
- R3: When all three inputs are valid and the output can accept, the unit drops stop (stop = 0) on all three inputs in the same cycle, and all three tokens are consumed at that clock edge.
- R4: While the output is valid and the output stop is 1, the output data and valid stay unchanged on the following cycles.
- R5: While the output is valid and the output stop is 1, stop is 1 toward all three inputs, even when all of them are valid.
- R6: While any of the three inputs is not valid, stop is 1 toward all three inputs, and no result appears on the output from that clock edge.
- R7: A result appears on the output one cycle after its inputs are consumed. In the cycle a held result drains (output stop = 0), a new result is accepted, so the unit sustains one result per cycle.
- R8: While reset is asserted and right after it is released, output valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_data_i | input | DATA_W | Operand A, forwarded when the predicate is true |
| a_valid_i | input | 1 | Operand A token present |
| a_stop_o | output | 1 | Back-pressure to the operand A producer |
| b_data_i | input | DATA_W | Operand B, forwarded when the predicate is false |
| b_valid_i | input | 1 | Operand B token present |
| b_stop_o | output | 1 | Back-pressure to the operand B producer |
| cond_data_i | input | COND_W | Condition word, truncated to the predicate |
| cond_valid_i | input | 1 | Condition token present |
| cond_stop_o | output | 1 | Back-pressure to the condition producer |
| z_data_o | output | DATA_W | Selected result |
| z_valid_o | output | 1 | Result token present |
| z_stop_i | input | 1 | Back-pressure from the result consumer |

## Verification
The bench builds the unit with its default 32-bit operand and condition widths. It uses condition words with only the lowest bit set or only the top bit set. These reach both ends of the truncation reduction, so a reduction that misses either end is caught. Stalled and streaming phases use the same widths. They show that the single output slot accepts a new result while its held result drains.

// File: rtl/elsel_pkg.sv
package elsel_pkg;
  typedef enum logic {
    PICK_B = 1'b0,
    PICK_A = 1'b1
  } pick_e;
endpackage

// File: rtl/pred_trunc.sv
module pred_trunc
  import elsel_pkg::*;
#(
  parameter int COND_W = 32
) (
  input  logic [COND_W-1:0] cond_i,
  output pick_e             pick_o
);
  // nonzero word -> true predicate
  assign pick_o = (|cond_i) ? PICK_A : PICK_B;
endmodule

// File: rtl/tok_join.sv
module tok_join #(
  parameter int N = 3
) (
  input  logic [N-1:0] valid_i,
  output logic [N-1:0] stop_o,
  output logic         valid_o,
  input  logic         stop_i
);
  logic all_v;
  logic fire;

  assign all_v   = &valid_i;
  assign fire    = all_v & ~stop_i;
  assign valid_o = all_v;

  // every input released only on a joint fire
  for (genvar g = 0; g < N; g++) begin : g_stop
    assign stop_o[g] = ~fire;
  end
endmodule

// File: rtl/out_slot.sv
module out_slot #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         valid_i,
  output logic         stop_o,
  output logic [W-1:0] q_o,
  output logic         valid_o,
  input  logic         stop_i
);
  logic         full_q;
  logic [W-1:0] data_q;
  logic         load;

  // blocked only when holding a result that cannot leave
  assign stop_o = full_q & stop_i;
  assign load   = valid_i & ~stop_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (load) begin
      full_q <= 1'b1;
      data_q <= d_i;
    end else if (!stop_i) begin
      full_q <= 1'b0;
    end
  end

  assign q_o     = data_q;
  assign valid_o = full_q;
endmodule

// File: rtl/elastic_pred_select.sv
module elastic_pred_select
  import elsel_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int COND_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic              a_valid_i,
  output logic              a_stop_o,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic              b_valid_i,
  output logic              b_stop_o,
  input  logic [COND_W-1:0] cond_data_i,
  input  logic              cond_valid_i,
  output logic              cond_stop_o,
  output logic [DATA_W-1:0] z_data_o,
  output logic              z_valid_o,
  input  logic              z_stop_i
);
  localparam int NUM_IN = 3;

  pick_e              pick;
  logic [NUM_IN-1:0]  in_valid;
  logic [NUM_IN-1:0]  in_stop;
  logic               join_valid;
  logic               slot_stop;
  logic [DATA_W-1:0]  sel_data;

  pred_trunc #(.COND_W(COND_W)) u_trunc (
    .cond_i (cond_data_i),
    .pick_o (pick)
  );

  assign in_valid = {cond_valid_i, b_valid_i, a_valid_i};

  tok_join #(.N(NUM_IN)) u_join (
    .valid_i (in_valid),
    .stop_o  (in_stop),
    .valid_o (join_valid),
    .stop_i  (slot_stop)
  );

  assign a_stop_o    = in_stop[0];
  assign b_stop_o    = in_stop[1];
  assign cond_stop_o = in_stop[2];

  assign sel_data = (pick == PICK_A) ? a_data_i : b_data_i;

  out_slot #(.W(DATA_W)) u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (sel_data),
    .valid_i (join_valid),
    .stop_o  (slot_stop),
    .q_o     (z_data_o),
    .valid_o (z_valid_o),
    .stop_i  (z_stop_i)
  );
endmodule

// File: rtl/elsel_chk.sv
module elsel_chk #(
  parameter int DATA_W = 32,
  parameter int COND_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] a_data_i,
  input logic              a_valid_i,
  input logic              a_stop_o,
  input logic [DATA_W-1:0] b_data_i,
  input logic              b_valid_i,
  input logic              b_stop_o,
  input logic [COND_W-1:0] cond_data_i,
  input logic              cond_valid_i,
  input logic              cond_stop_o,
  input logic [DATA_W-1:0] z_data_o,
  input logic              z_valid_o,
  input logic              z_stop_i
);
  logic all_v;
  logic fire;
  assign all_v = a_valid_i & b_valid_i & cond_valid_i;
  assign fire  = all_v & ~a_stop_o;

  AST_PICK_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && (cond_data_i != '0) |=> z_valid_o && z_data_o == $past(a_data_i)); // R1
  AST_PICK_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && (cond_data_i == '0) |=> z_valid_o && z_data_o == $past(b_data_i)); // R2
  AST_JOINT_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_stop_o == b_stop_o) && (b_stop_o == cond_stop_o)); // R3
  AST_HOLD_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_valid_o && z_stop_i |=> z_valid_o && $stable(z_data_o)); // R4
  AST_STALL_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_valid_o && z_stop_i |-> a_stop_o && b_stop_o && cond_stop_o); // R5
  AST_NO_PARTIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_v |-> a_stop_o && b_stop_o && cond_stop_o); // R6
  AST_EMPTY_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_v && (!z_valid_o || !z_stop_i) |=> !z_valid_o); // R6
  AST_REFILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_valid_o && !z_stop_i && all_v |-> !a_stop_o); // R7
endmodule

bind elastic_pred_select elsel_chk #(.DATA_W(DATA_W), .COND_W(COND_W)) u_chk (.*);

// File: tb/sim_elastic_pred_select.sv
module sim_elastic_pred_select;
  localparam int DW = 32;
  localparam int CW = 32;
  localparam int NV = 6;
  // {a, b, cond, expect_a}
  localparam logic [3*32:0] VEC [NV] = '{
    {32'h1111_0001, 32'h2222_0002, 32'h0000_0001, 1'b1},
    {32'h1111_0003, 32'h2222_0004, 32'h0000_0000, 1'b0},
    {32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h8000_0000, 1'b1},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    {32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'hFFFF_FFFF, 1'b1},
    {32'h0123_4567, 32'h89AB_CDEF, 32'h0001_0000, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] a_d = '0, b_d = '0;
  logic [CW-1:0] c_d = '0;
  logic          a_v = 1'b0, b_v = 1'b0, c_v = 1'b0, z_stop = 1'b0;
  logic          a_s, b_s, c_s, z_v;
  logic [DW-1:0] z_d;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  elastic_pred_select #(.DATA_W(DW), .COND_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .a_data_i(a_d), .a_valid_i(a_v), .a_stop_o(a_s),
    .b_data_i(b_d), .b_valid_i(b_v), .b_stop_o(b_s),
    .cond_data_i(c_d), .cond_valid_i(c_v), .cond_stop_o(c_s),
    .z_data_o(z_d), .z_valid_o(z_v), .z_stop_i(z_stop)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [CW-1:0] c,
                       input logic av, input logic bv, input logic cv);
    a_d = a; b_d = b; c_d = c; a_v = av; b_v = bv; c_v = cv;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    // R8 reset state
    #15;
    chk("R8 valid in reset", {31'b0, z_v}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R8 valid after reset", {31'b0, z_v}, 0);

    // R1/R2/R3/R7 streaming table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][96:65], VEC[i][64:33], VEC[i][32:1], 1'b1, 1'b1, 1'b1);
      #1;
      chk("R3 joint ack", {29'b0, a_s, b_s, c_s}, 0);
      @(negedge clk);
      chk("R7 valid next cycle", {31'b0, z_v}, 1);
      if (VEC[i][0]) chk("R1 pick A", z_d, VEC[i][96:65]);
      else           chk("R2 pick B", z_d, VEC[i][64:33]);
    end
    drive('0, '0, '0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R7 drained", {31'b0, z_v}, 0);

    // R6 missing condition
    drive(32'h7777_7777, 32'h8888_8888, 32'h1, 1'b1, 1'b1, 1'b0);
    #1;
    chk("R6 stops high", {29'b0, a_s, b_s, c_s}, 3'b111);
    @(negedge clk);
    chk("R6 no output", {31'b0, z_v}, 0);
    drive(32'h7777_7777, 32'h8888_8888, 32'h1, 1'b0, 1'b1, 1'b1);
    #1;
    chk("R6 stops high A missing", {29'b0, a_s, b_s, c_s}, 3'b111);
    @(negedge clk);
    chk("R6 no output A missing", {31'b0, z_v}, 0);

    // R4/R5 stall with held result
    z_stop = 1'b1;
    drive(32'h3333_3333, 32'h4444_4444, 32'h0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    chk("R2 loaded under stop", z_d, 32'h4444_4444);
    held = z_d;
    drive(32'h5555_5555, 32'h6666_6666, 32'h0000_0100, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R5 stall upstream", {29'b0, a_s, b_s, c_s}, 3'b111);
      @(negedge clk);
      chk("R4 valid held", {31'b0, z_v}, 1);
      chk("R4 data held", z_d, held);
    end
    // R7 drain and refill same cycle
    z_stop = 1'b0;
    #1;
    chk("R7 accept while draining", {29'b0, a_s, b_s, c_s}, 0);
    @(negedge clk);
    chk("R7 refill valid", {31'b0, z_v}, 1);
    chk("R1 refill data", z_d, 32'h5555_5555);
    drive('0, '0, '0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R7 empty at end", {31'b0, z_v}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule